// File: doc/BRIEF.md
# Shared Receive Queue for an Eight-Line Serial Controller

This block gathers received characters and modem-status change events from eight serial lines into one first-in first-out queue. Each queued entry records which line it came from, the character, and any parity, framing or overrun condition. A modem change on a line is queued as a marker entry in the same stream as characters, so software sees events and data in arrival order. Software drains the queue one 16-bit word per read from a single buffer address; a read of an empty queue returns a word whose valid bit is clear.

A small control/status word carries a receive-interrupt flag and its enable, plus a master-clear command. Writing to the buffer address does not enter the queue; it loads an interrupt-delay threshold, so the flag can wait until several entries have collected. The line deserialisers are not part of this block; a strobe interface delivering one character with its line number and error flags stands in for them.

Top module: `rx_silo`

## Requirements
- R1: A read at the buffer address (`bus_addr`=1) returns bit 15 set for a valid entry, the source line in bits 10:8 and the character in bits 7:0; with the queue empty it returns 16'h0000.
- R2: A character strobed with `rx_perr` is queued with bit 12 set and one strobed with `rx_ferr` with bit 13 set.
- R3: A pulse on `mdm_chg[n]` queues an entry with bit 11 set, line n and character 8'h00, at the earliest one cycle after the pulse; it is accepted whatever `line_en` holds. When several lines are pending the lowest line goes first, and a character strobe in the same cycle takes the queue slot ahead of them.
- R4: A character strobe whose line has its `line_en` bit clear is discarded.
- R5: The queue holds 64 entries in arrival order; each read at the buffer address removes exactly one entry, and a read of an empty queue changes nothing.
- R6: A character arriving while 64 entries are held is dropped, even if a read occurs in the same cycle; the next entry accepted from any source then carries bit 14, and only that entry.
- R7: Modem-change events that arrive while the queue is full stay pending and are queued once space frees up.
- R8: The control word (`bus_addr`=0) reads the receive flag in bit 7 and the interrupt enable in bit 6, all other bits 0; a write sets the enable from bit 6; `rx_irq` is the flag AND the enable.
- R9: A write at the buffer address loads the threshold from bits 6:0 (0 acts as 1, reset value 1) and never enters the queue; the flag rises in the cycle the occupancy reaches the threshold and then stays set until the queue is empty.
- R10: Writing the control word with bit 5 set empties the queue, discards pending modem events and the pending overrun mark, and clears the flag; bit 5 reads back as 0.
- R11: While `rst` is high at a clock edge the queue, pending events, flag, enable and overrun mark clear and the threshold returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_stb | input | 1 | Character delivered this cycle |
| rx_line | input | 3 | Line of the delivered character |
| rx_char | input | 8 | Delivered character |
| rx_perr | input | 1 | Parity error on the delivered character |
| rx_ferr | input | 1 | Framing error (break) on the delivered character |
| line_en | input | 8 | Per-line receive enable |
| mdm_chg | input | 8 | Per-line modem-status change pulse |
| bus_addr | input | 1 | 0 = control word, 1 = buffer / threshold |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops at the buffer address) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench fills the queue to exactly 64 entries and offers a 65th character, then frees space while a modem event waits: a design with an off-by-one full test would keep the extra character, and one that loses pending events or hangs the overrun mark on the wrong entry would show a missing or misflagged marker word. It strobes a character and three modem events in one cycle, which exposes a wrong slot priority or a highest-first pick. The threshold test reads the queue back below the threshold, where a flag computed from the level instead of held would drop early, and the master-clear test refills afterwards to catch an overrun mark that survived the clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int LINES  = 8;
    localparam int LINE_W = $clog2(LINES);
    localparam int DATA_W = 8;
    localparam int WORD_W = 16;

    localparam int CSR_FLAG = 7;
    localparam int CSR_IEN  = 6;
    localparam int CSR_MRST = 5;

    typedef enum logic {
        ADDR_CSR  = 1'b0,
        ADDR_RBUF = 1'b1
    } rxq_addr_e;

    // Field order fixes the read-word layout: ovr 14, ferr 13, perr 12,
    // dsc 11, line 10:8, data 7:0; the valid bit is prepended as bit 15.
    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic              dsc;
        logic [LINE_W-1:0] line;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    function automatic logic [WORD_W-1:0] rxq_pack(input logic valid, input rxq_entry_t e);
        return valid ? {1'b1, e} : '0;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       push,
    input  rxq_entry_t push_data,
    input  logic       pop,
    output rxq_entry_t head,
    output logic       empty,
    output logic       full,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt
);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_comb begin
        if (clr) count_nxt = '0;
        else     count_nxt = count + CW'(push_ok) - CW'(pop_ok);
    end

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= count_nxt;
        end
    end

endmodule

// File: rtl/rxq_merge.sv
module rxq_merge
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rx_stb,
    input  logic [LINE_W-1:0] rx_line,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic [LINES-1:0]  line_en,
    input  logic [LINES-1:0]  mdm_chg,
    input  logic              full,
    output logic              push,
    output rxq_entry_t        push_data
);

    logic [LINES-1:0]  pend;
    logic [LINE_W-1:0] gnt_idx;
    logic              gnt_any;
    logic              char_ok;
    logic              char_drop;
    logic              dsc_take;
    logic              ovr_q;

    assign char_ok   = rx_stb && line_en[rx_line];
    assign char_drop = char_ok && full;
    assign dsc_take  = !char_ok && gnt_any && !full;
    assign push      = (char_ok || gnt_any) && !full;

    // Lowest pending line wins: scan downward so the last hit is the lowest.
    always_comb begin
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                gnt_any = 1'b1;
                gnt_idx = LINE_W'(i);
            end
        end
    end

    always_comb begin
        push_data     = '0;
        push_data.ovr = ovr_q;
        if (char_ok) begin
            push_data.line = rx_line;
            push_data.data = rx_char;
            push_data.perr = rx_perr;
            push_data.ferr = rx_ferr;
        end else begin
            push_data.line = gnt_idx;
            push_data.dsc  = 1'b1;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst || clr) pend[g] <= 1'b0;
            else            pend[g] <= (pend[g] && !(dsc_take && gnt_idx == LINE_W'(g))) || mdm_chg[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)     ovr_q <= 1'b0;
        else if (char_drop) ovr_q <= 1'b1;
        else if (push)      ovr_q <= 1'b0;
    end

endmodule

// File: rtl/rxq_ctl.sv
module rxq_ctl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int TW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [CW-1:0]     count_nxt,
    output logic              clr,
    output logic              flag,
    output logic              ien,
    output logic [WORD_W-1:0] csr_word
);

    logic [TW-1:0] thr;
    logic [TW-1:0] thr_eff;
    logic          csr_wr;
    logic          thr_wr;
    logic          flag_nxt;

    assign csr_wr  = bus_wr && (bus_addr == ADDR_CSR);
    assign thr_wr  = bus_wr && (bus_addr == ADDR_RBUF);
    assign clr     = csr_wr && bus_wdata[CSR_MRST];
    assign thr_eff = (thr == '0) ? TW'(1) : thr;

    always_comb begin
        if (clr || count_nxt == '0) flag_nxt = 1'b0;
        else flag_nxt = flag || (32'(count_nxt) >= 32'(thr_eff));
    end

    always_comb begin
        csr_word           = '0;
        csr_word[CSR_FLAG] = flag;
        csr_word[CSR_IEN]  = ien;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr  <= TW'(1);
            ien  <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (thr_wr) thr <= bus_wdata[TW-1:0];
            if (csr_wr) ien <= bus_wdata[CSR_IEN];
            flag <= flag_nxt;
        end
    end

endmodule

// File: rtl/rx_silo.sv
module rx_silo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_stb,
    input  logic [2:0]        rx_line,
    input  logic [7:0]        rx_char,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic [7:0]        line_en,
    input  logic [7:0]        mdm_chg,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              rx_irq
);

    rxq_entry_t      push_data;
    rxq_entry_t      head;
    logic            push;
    logic            pop;
    logic            empty;
    logic            full;
    logic            clr;
    logic            flag;
    logic            ien;
    logic [CW-1:0]   count;
    logic [CW-1:0]   count_nxt;
    logic [WORD_W-1:0] csr_word;

    assign pop = bus_rd && (bus_addr == ADDR_RBUF);

    rxq_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .rx_stb    (rx_stb),
        .rx_line   (rx_line),
        .rx_char   (rx_char),
        .rx_perr   (rx_perr),
        .rx_ferr   (rx_ferr),
        .line_en   (line_en),
        .mdm_chg   (mdm_chg),
        .full      (full),
        .push      (push),
        .push_data (push_data)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .full      (full),
        .count     (count),
        .count_nxt (count_nxt)
    );

    rxq_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .count_nxt (count_nxt),
        .clr       (clr),
        .flag      (flag),
        .ien       (ien),
        .csr_word  (csr_word)
    );

    assign bus_rdata = (bus_addr == ADDR_RBUF) ? rxq_pack(!empty, head) : csr_word;
    assign rx_irq    = flag && ien;

endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] count,
    input logic          empty,
    input logic          full,
    input logic          pop,
    input logic          clr,
    input logic          flag,
    input logic          rx_irq,
    input logic          bus_addr,
    input logic [15:0]   bus_rdata
);

    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r8_irq_needs_data: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> !empty);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> (empty || flag));

    a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);

    a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !clr) |=> full);

    a_r1_empty_word: assert property (@(posedge clk) disable iff (rst)
        (empty && bus_addr) |-> (bus_rdata == 16'h0000));

endmodule

bind rx_silo rx_silo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .count     (count),
    .empty     (empty),
    .full      (full),
    .pop       (pop),
    .clr       (clr),
    .flag      (flag),
    .rx_irq    (rx_irq),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/test_rx_silo.sv
`timescale 1ns/1ps
module test_rx_silo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_stb = 1'b0;
    logic [2:0]  rx_line = '0;
    logic [7:0]  rx_char = '0;
    logic        rx_perr = 1'b0;
    logic        rx_ferr = 1'b0;
    logic [7:0]  line_en = 8'h7F;
    logic [7:0]  mdm_chg = '0;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rx_silo i_rx_silo (
        .clk(clk), .rst(rst), .rx_stb(rx_stb), .rx_line(rx_line), .rx_char(rx_char),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .line_en(line_en), .mdm_chg(mdm_chg),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_irq(rx_irq)
    );

    // vector: {line[2:0], perr, ferr, char[7:0]}
    localparam int NV = 6;
    localparam logic [12:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0, 8'h41},
        {3'd3, 1'b1, 1'b0, 8'h5A},
        {3'd7, 1'b0, 1'b0, 8'h99},
        {3'd5, 1'b0, 1'b1, 8'h00},
        {3'd6, 1'b1, 1'b1, 8'hFF},
        {3'd2, 1'b0, 1'b0, 8'h3C}
    };

    function automatic logic [15:0] char_word(input logic [2:0] ln, input logic pe,
                                              input logic fe, input logic ov, input logic [7:0] ch);
        return {1'b1, ov, fe, pe, 1'b0, ln, ch};
    endfunction

    function automatic logic [15:0] dsc_word(input logic [2:0] ln, input logic ov);
        return {1'b1, ov, 2'b00, 1'b1, ln, 8'h00};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] ln, input logic [7:0] ch, input logic pe, input logic fe);
        rx_stb = 1'b1; rx_line = ln; rx_char = ch; rx_perr = pe; rx_ferr = fe;
        @(negedge clk);
        rx_stb = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    task automatic rd_word(output logic [15:0] w);
        bus_addr = 1'b1; bus_rd = 1'b1;
        #1 w = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [15:0] w);
        bus_addr = a;
        #1 w = bus_rdata;
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 / R1: reset state
        peek(1'b0, w); check("R11 csr after reset", w, 16'h0000);
        peek(1'b1, w); check("R1 empty buffer word", w, 16'h0000);
        check("R11 irq after reset", {15'b0, rx_irq}, 16'h0000);

        // R1 R2 R4 R5: vector walk, line 7 disabled
        for (int i = 0; i < NV; i++) push(VEC[i][12:10], VEC[i][7:0], VEC[i][9], VEC[i][8]);
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12:10] != 3'd7) begin
                rd_word(w);
                check("R1 R2 R4 vector word", w,
                      char_word(VEC[i][12:10], VEC[i][9], VEC[i][8], 1'b0, VEC[i][7:0]));
            end
        end
        rd_word(w); check("R5 read of empty queue", w, 16'h0000);
        push(3'd4, 8'h77, 1'b0, 1'b0);
        rd_word(w); check("R5 entry after empty read", w, char_word(3'd4, 1'b0, 1'b0, 1'b0, 8'h77));

        // R3: char and modem events in one cycle, line 7 disabled for chars
        mdm_chg = 8'b1010_1000;
        push(3'd0, 8'h41, 1'b0, 1'b0);
        mdm_chg = '0;
        repeat (5) @(negedge clk);
        rd_word(w); check("R3 char takes slot first", w, char_word(3'd0, 1'b0, 1'b0, 1'b0, 8'h41));
        rd_word(w); check("R3 lowest event line 3", w, dsc_word(3'd3, 1'b0));
        rd_word(w); check("R3 event line 5", w, dsc_word(3'd5, 1'b0));
        rd_word(w); check("R3 event on disabled line 7", w, dsc_word(3'd7, 1'b0));
        rd_word(w); check("R3 nothing more", w, 16'h0000);

        // R9: threshold 3
        bus_write(1'b1, 16'h0003);
        peek(1'b1, w); check("R9 threshold write not queued", w, 16'h0000);
        push(3'd1, 8'h01, 1'b0, 1'b0);
        push(3'd1, 8'h02, 1'b0, 1'b0);
        peek(1'b0, w); check("R9 flag below threshold", w, 16'h0000);
        push(3'd1, 8'h03, 1'b0, 1'b0);
        peek(1'b0, w); check("R9 flag at threshold", w, 16'h0080);
        check("R8 irq masked", {15'b0, rx_irq}, 16'h0000);
        bus_write(1'b0, 16'h0040);
        check("R8 irq enabled", {15'b0, rx_irq}, 16'h0001);
        rd_word(w);
        peek(1'b0, w); check("R9 flag held below threshold", w, 16'h00C0);
        rd_word(w); rd_word(w);
        peek(1'b0, w); check("R9 flag drops when empty", w, 16'h0040);
        check("R8 irq drops", {15'b0, rx_irq}, 16'h0000);
        bus_write(1'b1, 16'h0000);

        // R6 R7: fill, overflow, pending event
        for (int i = 0; i < 64; i++) push(3'd1, 8'(i), 1'b0, 1'b0);
        push(3'd2, 8'hEE, 1'b0, 1'b0);
        mdm_chg = 8'b0001_0000;
        @(negedge clk);
        mdm_chg = '0;
        repeat (3) @(negedge clk);
        rd_word(w); check("R5 first of full queue", w, char_word(3'd1, 1'b0, 1'b0, 1'b0, 8'h00));
        repeat (3) @(negedge clk);
        rd_word(w); check("R5 second of full queue", w, char_word(3'd1, 1'b0, 1'b0, 1'b0, 8'h01));
        push(3'd2, 8'hAA, 1'b0, 1'b0);
        begin
            int bad = 0;
            for (int i = 2; i < 64; i++) begin
                rd_word(w);
                if (w !== char_word(3'd1, 1'b0, 1'b0, 1'b0, 8'(i))) bad++;
            end
            check("R5 R6 order kept, dropped char absent", 16'(bad), 16'h0000);
        end
        rd_word(w); check("R6 R7 pending event carries overrun", w, dsc_word(3'd4, 1'b1));
        rd_word(w); check("R6 overrun only once", w, char_word(3'd2, 1'b0, 1'b0, 1'b0, 8'hAA));
        rd_word(w); check("R5 drained", w, 16'h0000);

        // R10: master clear with pending event and overrun mark
        for (int i = 0; i < 64; i++) push(3'd0, 8'(i), 1'b0, 1'b0);
        push(3'd3, 8'h55, 1'b0, 1'b0);
        mdm_chg = 8'b0100_0000;
        @(negedge clk);
        mdm_chg = '0;
        bus_write(1'b0, 16'h0060);
        repeat (4) @(negedge clk);
        peek(1'b1, w); check("R10 queue empty after clear", w, 16'h0000);
        peek(1'b0, w); check("R10 csr after clear", w, 16'h0040);
        push(3'd0, 8'h11, 1'b0, 1'b0);
        check("R8 R9 irq on first entry", {15'b0, rx_irq}, 16'h0001);
        rd_word(w); check("R10 no overrun mark survives", w, char_word(3'd0, 1'b0, 1'b0, 1'b0, 8'h11));

        // R11: reset with data held
        push(3'd6, 8'h66, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        peek(1'b1, w); check("R11 queue cleared by reset", w, 16'h0000);
        peek(1'b0, w); check("R11 enable cleared by reset", w, 16'h0000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule